// File: doc/BRIEF.md
# Shiftable Timing Error Counter Chain

This block collects timing error statistics from a circuit that runs with speculative, error-detecting flip-flops. The circuit is divided into regions. Each region merges the error flags of its flip-flops into a single hit signal. A small saturating counter records how many clock cycles had at least one hit. The counters are not each routed to a central point. Instead, every counter can turn its own bits into one segment of a shared serial shift chain.

Normally all counters accumulate. When any counter reaches all-ones, a sequencer switches every counter into shifting mode on the same clock edge. A collector at the head of the chain then pulls out one bit per clock until all N·W bits have arrived. It rebuilds the per-region counts and presents them on a parallel bus with a one-cycle valid strobe. On that same edge it clears all counters, and counting resumes. The block only observes the error flags and never feeds back into the datapath that produces them.

Top module: `tspec_err_chain`

## Requirements
- R1: While `rst` is high and after its release, `shifting`, `counts_valid` and `counts_out` are all zero until the first collection.
- R2: In counting mode, a region's counter advances by exactly one for each clock in which at least one of its F flags is high. Any number of simultaneous flags in that region counts as one. A region whose flags are all low holds its value.
- R3: A counter that reaches all-ones (2^W−1) stays there and does not wrap. Its full indication remains set until the counters are cleared by a collection.
- R4: Suppose a counter reaches all-ones at clock edge E. At edge E+1, `shifting` rises. That edge still counts errors, and the values the counters hold after E+1 form the snapshot.
- R5: `shifting` stays high for exactly N·W+1 consecutive cycles: N·W shift cycles and then one clearing cycle.
- R6: Error flags that are high while `shifting` is high have no effect on any count, either in the snapshot or after collection.
- R7: Right after `shifting` falls, `counts_valid` is high for exactly one cycle. Bits [i·W +: W] of `counts_out` then hold region i's snapshot, where region 0 is nearest the collector and each counter leaves MSB first. `counts_out` changes only on that strobe.
- R8: After a collection, all counters restart from zero. The next snapshot reflects only the errors counted after the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| err_flags | input | N·F | Error flags, region i in bits [i·F +: F] |
| shifting | output | 1 | High while the chain is shifting or being cleared |
| counts_valid | output | 1 | One-cycle strobe marking a new `counts_out` |
| counts_out | output | N·W | Rebuilt per-region counts, region i in bits [i·W +: W] |

## Verification
The bench drives every flag of one region at once. A design that summed the flags instead of OR-ing them would then report counts above the cycle count. It holds a region's flags high past the point where that region saturates, which catches a counter that wraps back to zero. During every shift window it raises all flags, so a counter that still counted while shifting would corrupt either the snapshot or the next one. Long pseudo-random runs check each snapshot against a model of all regions. That model catches a chain wired in the wrong region order or bit order, an off-by-one shift length, and a full event that is noticed one cycle early or late.

// File: rtl/tspec_err_chain_pkg.sv
package tspec_err_chain_pkg;
  typedef enum logic [1:0] {
    ST_COUNT = 2'd0,
    ST_SHIFT = 2'd1,
    ST_WRAP  = 2'd2
  } chain_state_t;
endpackage

// File: rtl/tspec_region_ctr.sv
module tspec_region_ctr #(
  parameter int W = 4,
  parameter int F = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [F-1:0] flags,
  input  logic         count_en,
  input  logic         shift_en,
  input  logic         clear,
  input  logic         ser_in,
  output logic         ser_out,
  output logic         full
);
  localparam logic [W-1:0] MAXV = {W{1'b1}};
  localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] cnt;
  logic         hit;

  assign hit     = |flags;
  assign ser_out = cnt[W-1];

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt  <= '0;
      full <= 1'b0;
    end else if (shift_en) begin
      cnt <= {cnt[W-2:0], ser_in};
    end else if (count_en) begin
      if (hit && (cnt != MAXV)) cnt <= cnt + ONE;
      full <= (cnt == MAXV) || (hit && (cnt == MAXV - ONE));
    end
  end
endmodule

// File: rtl/tspec_chain_seq.sv
module tspec_chain_seq
  import tspec_err_chain_pkg::*;
#(
  parameter int N = 4,
  parameter int W = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic full_any,
  output logic count_en,
  output logic shift_en,
  output logic clear,
  output logic shifting
);
  localparam int NW = N * W;
  localparam int BW = $clog2(NW + 1);
  localparam logic [BW-1:0] LAST = BW'(NW - 1);

  chain_state_t   state;
  logic [BW-1:0]  bitcnt;

  assign count_en = (state == ST_COUNT);
  assign shift_en = (state == ST_SHIFT);
  assign clear    = (state == ST_WRAP);
  assign shifting = (state != ST_COUNT);

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_COUNT;
      bitcnt <= '0;
    end else begin
      case (state)
        ST_COUNT: begin
          bitcnt <= '0;
          if (full_any) state <= ST_SHIFT;
        end
        ST_SHIFT: begin
          bitcnt <= bitcnt + 1'b1;
          if (bitcnt == LAST) state <= ST_WRAP;
        end
        default: state <= ST_COUNT;
      endcase
    end
  end
endmodule

// File: rtl/tspec_collector.sv
module tspec_collector #(
  parameter int N = 4,
  parameter int W = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           ser_in,
  input  logic           cap_en,
  input  logic           load_out,
  output logic [N*W-1:0] counts_out,
  output logic           counts_valid
);
  localparam int NW = N * W;

  logic [NW-1:0] sr;
  logic [NW-1:0] ordered;

  // first bit received ends up at the top: region 0 occupies the top field
  for (genvar i = 0; i < N; i++) begin : g_map
    assign ordered[i*W +: W] = sr[(N-1-i)*W +: W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sr           <= '0;
      counts_out   <= '0;
      counts_valid <= 1'b0;
    end else begin
      if (cap_en) sr <= {sr[NW-2:0], ser_in};
      counts_valid <= load_out;
      if (load_out) counts_out <= ordered;
    end
  end
endmodule

// File: rtl/tspec_err_chain.sv
module tspec_err_chain #(
  parameter int N = 4,
  parameter int W = 4,
  parameter int F = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [N*F-1:0] err_flags,
  output logic           shifting,
  output logic           counts_valid,
  output logic [N*W-1:0] counts_out
);
  logic [N-1:0] full_vec;
  logic [N-1:0] ser;
  logic         full_any;
  logic         count_en, shift_en, clear;

  assign full_any = |full_vec;

  for (genvar i = 0; i < N; i++) begin : g_reg
    logic link_in;
    if (i == N - 1) begin : g_tail
      assign link_in = 1'b0;
    end else begin : g_mid
      assign link_in = ser[i+1];
    end
    tspec_region_ctr #(.W(W), .F(F)) ctr_i (
      .clk      (clk),
      .rst      (rst),
      .flags    (err_flags[i*F +: F]),
      .count_en (count_en),
      .shift_en (shift_en),
      .clear    (clear),
      .ser_in   (link_in),
      .ser_out  (ser[i]),
      .full     (full_vec[i])
    );
  end

  tspec_chain_seq #(.N(N), .W(W)) seq_i (
    .clk      (clk),
    .rst      (rst),
    .full_any (full_any),
    .count_en (count_en),
    .shift_en (shift_en),
    .clear    (clear),
    .shifting (shifting)
  );

  tspec_collector #(.N(N), .W(W)) col_i (
    .clk          (clk),
    .rst          (rst),
    .ser_in       (ser[0]),
    .cap_en       (shift_en),
    .load_out     (clear),
    .counts_out   (counts_out),
    .counts_valid (counts_valid)
  );
endmodule

// File: rtl/tspec_err_chain_chk.sv
module tspec_err_chain_chk #(
  parameter int N = 4,
  parameter int W = 4
) (
  input logic           clk,
  input logic           rst,
  input logic           full_any,
  input logic           shifting,
  input logic           counts_valid,
  input logic [N*W-1:0] counts_out
);
  localparam int NW = N * W;
  localparam int LW = $clog2(NW + 2) + 1;

  logic [LW-1:0] runlen;
  always_ff @(posedge clk) begin
    if (rst) runlen <= '0;
    else if (shifting) runlen <= runlen + 1'b1;
    else runlen <= '0;
  end

  p_full_starts_shift_r4: assert property (@(posedge clk) disable iff (rst)
    (full_any && !shifting) |=> shifting);
  p_shift_len_r5: assert property (@(posedge clk) disable iff (rst)
    (!shifting && $past(shifting)) |-> (int'(runlen) == NW + 1));
  p_valid_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    counts_valid |=> !counts_valid);
  p_valid_after_shift_r7: assert property (@(posedge clk) disable iff (rst)
    counts_valid |-> (!shifting && $past(shifting)));
  p_out_stable_r7: assert property (@(posedge clk) disable iff (rst)
    !counts_valid |-> $stable(counts_out));
endmodule

bind tspec_err_chain tspec_err_chain_chk #(.N(N), .W(W)) chk_i (
  .clk          (clk),
  .rst          (rst),
  .full_any     (full_any),
  .shifting     (shifting),
  .counts_valid (counts_valid),
  .counts_out   (counts_out)
);

// File: tb/tspec_err_chain_tb.sv
module tspec_err_chain_tb_top;
  localparam int N    = 3;
  localparam int W    = 3;
  localparam int F    = 2;
  localparam int NF   = N * F;
  localparam int NW   = N * W;
  localparam int MAXV = (1 << W) - 1;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [NF-1:0]  err_flags = '0;
  logic           shifting;
  logic           counts_valid;
  logic [NW-1:0]  counts_out;

  always #2 clk = ~clk;

  tspec_err_chain #(.N(N), .W(W), .F(F)) dut_i (
    .clk          (clk),
    .rst          (rst),
    .err_flags    (err_flags),
    .shifting     (shifting),
    .counts_valid (counts_valid),
    .counts_out   (counts_out)
  );

  int errors = 0;
  int checks = 0;
  int nvalid = 0;

  // reference model: 0 count, 1 shift, 2 clear
  int mst = 0;
  int k = 0;
  int mcnt [N];
  int mfull [N];
  int snap [N];
  logic [NW-1:0] exp_out = '0;
  string ptag = "R2";

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_edge(input logic [NF-1:0] f, output bit ev, output bit start);
    ev = 0;
    start = 0;
    case (mst)
      0: begin
        bit pf;
        pf = 0;
        for (int r = 0; r < N; r++) if (mfull[r] != 0) pf = 1;
        for (int r = 0; r < N; r++) begin
          if ((|f[r*F +: F]) && mcnt[r] < MAXV) mcnt[r]++;
          mfull[r] = (mcnt[r] == MAXV);
        end
        if (pf) begin
          mst = 1; k = 0; start = 1;
          for (int r = 0; r < N; r++) snap[r] = mcnt[r];
        end
      end
      1: begin
        k++;
        if (k == NW) mst = 2;
      end
      default: begin
        for (int r = 0; r < N; r++) begin mcnt[r] = 0; mfull[r] = 0; end
        mst = 0; ev = 1;
        for (int r = 0; r < N; r++) exp_out[r*W +: W] = W'(snap[r]);
      end
    endcase
  endtask

  task automatic step(input logic [NF-1:0] f);
    bit ev, start;
    err_flags = f;
    @(posedge clk);
    model_edge(f, ev, start);
    #1;
    chk(start ? "R4" : "R5", shifting, (mst != 0));
    chk("R7", counts_valid, ev);
    if (ev) begin
      nvalid++;
      chk(ptag, counts_out, exp_out);
    end
  endtask

  // during shifting all flags are driven high (R6)
  function automatic logic [NF-1:0] gate(input logic [NF-1:0] f);
    return (mst != 0) ? {NF{1'b1}} : f;
  endfunction

  task automatic wait_valid(input logic [NF-1:0] f);
    int start_n;
    start_n = nvalid;
    for (int i = 0; i < 400 && nvalid == start_n; i++) step(gate(f));
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int r = 0; r < N; r++) begin mcnt[r] = 0; mfull[r] = 0; snap[r] = 0; end
    repeat (3) @(posedge clk);
    #1;
    chk("R1", shifting, 0);
    chk("R1", counts_valid, 0);
    chk("R1", counts_out, 0);
    err_flags = {NF{1'b1}};
    @(posedge clk);
    #1;
    chk("R1", counts_out, 0);
    rst = 1'b0;
    err_flags = '0;
    step('0);
    step('0);
    chk("R1", shifting, 0);

    // R2: region 1 both flags every cycle, region 0 one flag on alternate cycles
    ptag = "R2";
    for (int i = 0; i < 30 && nvalid == 0; i++)
      step(gate((i % 2 == 0) ? 6'b001101 : 6'b001100));
    wait_valid('0);

    // R6: flags forced high during every shift window; R3: region 2 held high past saturation
    ptag = "R3";
    wait_valid(6'b110000);

    // R8: only the post-collection errors appear in the next snapshot
    ptag = "R8";
    for (int i = 0; i < 4; i++) step(gate(6'b000010));
    wait_valid(6'b100000);

    ptag = "R6";
    wait_valid(6'b111111);

    // R7: pseudo-random sweep over all flag patterns
    ptag = "R7";
    begin
      logic [15:0] lfsr = 16'hACE1;
      for (int i = 0; i < 3000; i++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        step(gate(lfsr[NF-1:0] & lfsr[NF+3:4]));
      end
    end
    chk("R7", (nvalid > 20), 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule